// File: doc/BRIEF.md
# Card Transfer Sequencer

This block sequences the data phase of a memory-card transfer once the data-bearing command has been answered. It decides, cycle by cycle, whether the card-side byte shifter may move data (`xfer_en`). It counts bytes inside each block and counts down the remaining blocks. It stops the transfer when the data FIFO cannot keep up or when a block ends. Each stop records a cause code that software can read.

Software starts a write by pulsing `den_wr` after the response has arrived. A read starts as soon as the response is reported. After a stop, software re-arms the transfer: `den_wr` for writes, `rcont_wr` for reads. At a block boundary, software may instead pulse `cmd_off` to abandon the sequence before it sends a stop command on its own. With `auto_mode` captured at the start, block boundaries no longer cause stops. A one-cycle `done` pulse marks both normal completion and an abort.

Top module: `card_xfer_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle: `xfer_en`, `halted`, `done` and `arm_flag` are 0, `halt_why` is 0, and both counters read 0.
- R2: After a write response (`resp_done` with `dir_rd`=0), `xfer_en` stays 0 until `den_wr` is pulsed. `den_wr` is accepted only while waiting after the write response, or while halted with cause 1 or 3. At any other time it is ignored and leaves `arm_flag` at 0. A read response sets `xfer_en` on the next cycle.
- R3: An accepted `den_wr` or `rcont_wr` sets `arm_flag` one cycle later. `arm_flag` clears itself in the cycle the sequencer consumes it, and at that same edge `xfer_en` rises.
- R4: During a write, `fifo_empty` high while transferring causes a halt with `halt_why`=1 (FIFO empty). An accepted `den_wr` resumes the transfer.
- R5: During a read, `fifo_full` high while transferring causes a halt with `halt_why`=2 (FIFO full). An accepted `rcont_wr` arms a resume, which takes effect only once `fifo_full` is low.
- R6: When the last byte of a block is strobed, `bytes_left` reloads the latched block length and `blocks_left` decrements. Without auto mode, if more blocks remain, the block halts with `halt_why`=3 (block boundary) until the direction's continue pulse arrives.
- R7: `cmd_off` during a block-boundary halt returns the block to idle. It pulses `done` for one cycle and clears the counters. `cmd_off` at any other time is ignored.
- R8: With `auto_mode` captured at the response, block boundaries pass without a halt and without any continue pulse.
- R9: Strobing the final byte of the final block returns the block to idle with both counters at 0 and pulses `done` for exactly one cycle.
- R10: `byte_stb` is counted only while `xfer_en` is 1. At any other time it leaves `bytes_left` unchanged.
- R11: `halt_why` is 0 whenever `halted` is 0, and `xfer_en` and `halted` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resp_done | input | 1 | Pulse: response to a data command received |
| dir_rd | input | 1 | Direction sampled with `resp_done`: 1 read, 0 write |
| auto_mode | input | 1 | Sampled with `resp_done`: skip block-boundary halts |
| blk_len | input | LEN_W | Bytes per block, latched at `resp_done`, nonzero |
| blk_cnt | input | CNT_W | Number of blocks, latched at `resp_done`, nonzero |
| den_wr | input | 1 | Pulse: software writes 1 to the data-enable control |
| rcont_wr | input | 1 | Pulse: software writes 1 to the read-continue control |
| cmd_off | input | 1 | Pulse: abort the sequence at a block-boundary halt |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| fifo_full | input | 1 | Receive FIFO full flag |
| byte_stb | input | 1 | One byte moved by the card-side shifter |
| xfer_en | output | 1 | Shifter may move data |
| halted | output | 1 | Transfer paused awaiting software |
| halt_why | output | 2 | Halt cause: 0 none, 1 FIFO empty, 2 FIFO full, 3 block boundary |
| done | output | 1 | One-cycle pulse at completion or abort |
| arm_flag | output | 1 | Self-clearing continue request, visible to software |
| bytes_left | output | LEN_W | Bytes remaining in the current block |
| blocks_left | output | CNT_W | Blocks remaining, including the current one |

## Verification
The assertions assume that `blk_len` and `blk_cnt` are nonzero when `resp_done` arrives, and that `resp_done` comes only while the block is idle. The stimulus programs lengths of 2 to 4 and counts of 2 to 3, and issues each response from idle. The checks also assume that the FIFO flag of the other direction has no meaning, and that `byte_stb` may arrive at any time. The bench drives stray strobes and control pulses outside their windows to confirm that they are ignored.

// File: rtl/card_xfer_pkg.sv
package card_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_HALT = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        WHY_NONE  = 2'd0,
        WHY_EMPTY = 2'd1,
        WHY_FULL  = 2'd2,
        WHY_BLOCK = 2'd3
    } halt_why_e;

    // FIFO flag that stalls the transfer in the given direction
    function automatic logic stall_hit(input logic is_read, input logic fe, input logic ff);
        return is_read ? ff : fe;
    endfunction

    // Cause code recorded for a FIFO stall in the given direction
    function automatic halt_why_e stall_cause(input logic is_read);
        return is_read ? WHY_FULL : WHY_EMPTY;
    endfunction

endpackage

// File: rtl/card_xfer_arm.sv
module card_xfer_arm
    import card_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state,
    input  halt_why_e  why,
    input  logic       is_read,
    input  logic       den_wr,
    input  logic       rcont_wr,
    input  logic       drop,
    output logic       arm_q
);
    logic den_ok;
    logic rc_ok;

    always_comb begin
        den_ok = den_wr && !is_read &&
                 (state == ST_WAIT ||
                  (state == ST_HALT && (why == WHY_EMPTY || why == WHY_BLOCK)));
        rc_ok  = rcont_wr && is_read && state == ST_HALT &&
                 (why == WHY_FULL || why == WHY_BLOCK);
    end

    always_ff @(posedge clk) begin
        if (rst)       arm_q <= 1'b0;
        else if (drop) arm_q <= 1'b0;
        else           arm_q <= arm_q | den_ok | rc_ok;
    end
endmodule

// File: rtl/card_xfer_cnt.sv
module card_xfer_cnt #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] len_in,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [LEN_W-1:0] bytes_left,
    output logic [CNT_W-1:0] blocks_left,
    output logic             last_byte,
    output logic             last_block
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [LEN_W-1:0] len_q;

    assign last_byte  = (bytes_left == LEN_ONE);
    assign last_block = (blocks_left == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            len_q       <= '0;
            bytes_left  <= '0;
            blocks_left <= '0;
        end else if (load) begin
            len_q       <= len_in;
            bytes_left  <= len_in;
            blocks_left <= cnt_in;
        end else if (step) begin
            if (last_byte) begin
                blocks_left <= blocks_left - CNT_ONE;
                bytes_left  <= last_block ? '0 : len_q;
            end else begin
                bytes_left  <= bytes_left - LEN_ONE;
            end
        end
    end
endmodule

// File: rtl/card_xfer_seq.sv
module card_xfer_seq
    import card_xfer_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             resp_done,
    input  logic             dir_rd,
    input  logic             auto_mode,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [CNT_W-1:0] blk_cnt,
    input  logic             den_wr,
    input  logic             rcont_wr,
    input  logic             cmd_off,
    input  logic             fifo_empty,
    input  logic             fifo_full,
    input  logic             byte_stb,
    output logic             xfer_en,
    output logic             halted,
    output logic [1:0]       halt_why,
    output logic             done,
    output logic             arm_flag,
    output logic [LEN_W-1:0] bytes_left,
    output logic [CNT_W-1:0] blocks_left
);
    seq_state_e state_q, state_n;
    halt_why_e  why_q, why_n;
    logic       is_read_q, auto_q, done_q, done_n;
    logic       load, step, abort, consume;
    logic       last_byte, last_block;

    assign step = (state_q == ST_RUN) && byte_stb;
    assign load = (state_q == ST_IDLE) && resp_done;

    card_xfer_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .state    (state_q),
        .why      (why_q),
        .is_read  (is_read_q),
        .den_wr   (den_wr),
        .rcont_wr (rcont_wr),
        .drop     (consume | abort),
        .arm_q    (arm_flag)
    );

    card_xfer_cnt #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .clear       (abort),
        .step        (step),
        .len_in      (blk_len),
        .cnt_in      (blk_cnt),
        .bytes_left  (bytes_left),
        .blocks_left (blocks_left),
        .last_byte   (last_byte),
        .last_block  (last_block)
    );

    always_comb begin
        state_n = state_q;
        why_n   = why_q;
        done_n  = 1'b0;
        abort   = 1'b0;
        consume = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (resp_done) state_n = dir_rd ? ST_RUN : ST_WAIT;
            end
            ST_WAIT: begin
                if (arm_flag) begin
                    consume = 1'b1;
                    state_n = ST_RUN;
                end
            end
            ST_RUN: begin
                if (step && last_byte) begin
                    if (last_block) begin
                        state_n = ST_IDLE;
                        done_n  = 1'b1;
                    end else if (!auto_q) begin
                        state_n = ST_HALT;
                        why_n   = WHY_BLOCK;
                    end
                end else if (stall_hit(is_read_q, fifo_empty, fifo_full)) begin
                    state_n = ST_HALT;
                    why_n   = stall_cause(is_read_q);
                end
            end
            ST_HALT: begin
                if (cmd_off && why_q == WHY_BLOCK) begin
                    abort   = 1'b1;
                    state_n = ST_IDLE;
                    why_n   = WHY_NONE;
                    done_n  = 1'b1;
                end else if (arm_flag && !(why_q == WHY_FULL && fifo_full)) begin
                    consume = 1'b1;
                    state_n = ST_RUN;
                    why_n   = WHY_NONE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            why_q     <= WHY_NONE;
            is_read_q <= 1'b0;
            auto_q    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            why_q   <= why_n;
            done_q  <= done_n;
            if (load) begin
                is_read_q <= dir_rd;
                auto_q    <= auto_mode;
            end
        end
    end

    assign xfer_en  = (state_q == ST_RUN);
    assign halted   = (state_q == ST_HALT);
    assign halt_why = why_q;
    assign done     = done_q;
endmodule

// File: rtl/card_xfer_seq_chk.sv
module card_xfer_seq_chk #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_full,
    input logic             xfer_en,
    input logic             halted,
    input logic [1:0]       halt_why,
    input logic             done,
    input logic             arm_flag,
    input logic [LEN_W-1:0] bytes_left,
    input logic [CNT_W-1:0] blocks_left
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!xfer_en && !halted && !done && !arm_flag && blocks_left == '0)); // R1
    AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) (arm_flag && !(halted && halt_why == 2'd2 && fifo_full)) |=> !arm_flag); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (!xfer_en && !halted && bytes_left == '0 && blocks_left == '0)); // R9
    AST_WHY_CLEAR_RUN: assert property (@(posedge clk) disable iff (rst) !halted |-> halt_why == 2'd0); // R11
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst) !(xfer_en && halted)); // R11
    AST_HALT_HOLDS_BYTES: assert property (@(posedge clk) disable iff (rst) (halted && $past(halted)) |-> $stable(bytes_left)); // R10
endmodule

bind card_xfer_seq card_xfer_seq_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .fifo_full(fifo_full), .xfer_en(xfer_en), .halted(halted),
    .halt_why(halt_why), .done(done), .arm_flag(arm_flag),
    .bytes_left(bytes_left), .blocks_left(blocks_left)
);

// File: tb/test_card_xfer_seq.sv
module test_card_xfer_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 12;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic resp_done = 0, dir_rd = 0, auto_mode = 0;
    logic [LEN_W-1:0] blk_len = '0;
    logic [CNT_W-1:0] blk_cnt = '0;
    logic den_wr = 0, rcont_wr = 0, cmd_off = 0;
    logic fifo_empty = 0, fifo_full = 0, byte_stb = 0;
    logic xfer_en, halted, done, arm_flag;
    logic [1:0] halt_why;
    logic [LEN_W-1:0] bytes_left;
    logic [CNT_W-1:0] blocks_left;

    int n_chk = 0, n_err = 0;
    bit started = 0;

    // behavioural reference: 0 idle, 1 wait, 2 run, 3 halt
    int m_st = 0, m_why = 0, m_arm = 0, m_bytes = 0, m_blocks = 0, m_done = 0;
    int m_dir = 0, m_auto = 0, m_len = 0;
    int t_st, t_why, t_arm, t_bytes, t_blocks, t_done, t_acc, t_drop;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_xfer_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_card_xfer_seq (
        .clk(clk), .rst(rst), .resp_done(resp_done), .dir_rd(dir_rd), .auto_mode(auto_mode),
        .blk_len(blk_len), .blk_cnt(blk_cnt), .den_wr(den_wr), .rcont_wr(rcont_wr),
        .cmd_off(cmd_off), .fifo_empty(fifo_empty), .fifo_full(fifo_full), .byte_stb(byte_stb),
        .xfer_en(xfer_en), .halted(halted), .halt_why(halt_why), .done(done),
        .arm_flag(arm_flag), .bytes_left(bytes_left), .blocks_left(blocks_left)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_st = 0; m_why = 0; m_arm = 0; m_bytes = 0; m_blocks = 0; m_done = 0;
        end else begin
            t_st = m_st; t_why = m_why; t_bytes = m_bytes; t_blocks = m_blocks;
            t_done = 0; t_drop = 0;
            t_acc = ((den_wr && m_dir == 0 && (m_st == 1 || (m_st == 3 && (m_why == 1 || m_why == 3)))) ||
                     (rcont_wr && m_dir == 1 && m_st == 3 && (m_why == 2 || m_why == 3))) ? 1 : 0;
            case (m_st)
                0: if (resp_done) begin
                       m_dir = dir_rd; m_auto = auto_mode; m_len = int'(blk_len);
                       t_bytes = int'(blk_len); t_blocks = int'(blk_cnt);
                       t_st = dir_rd ? 2 : 1;
                   end
                1: if (m_arm != 0) begin t_drop = 1; t_st = 2; end
                2: if (byte_stb && m_bytes == 1) begin
                       t_blocks = m_blocks - 1;
                       if (m_blocks == 1) begin t_bytes = 0; t_st = 0; t_done = 1; end
                       else begin
                           t_bytes = m_len;
                           if (m_auto == 0) begin t_st = 3; t_why = 3; end
                       end
                   end else begin
                       if (byte_stb) t_bytes = m_bytes - 1;
                       if ((m_dir == 1) ? fifo_full : fifo_empty) begin
                           t_st = 3; t_why = (m_dir == 1) ? 2 : 1;
                       end
                   end
                default: if (cmd_off && m_why == 3) begin
                       t_drop = 1; t_st = 0; t_why = 0; t_bytes = 0; t_blocks = 0; t_done = 1;
                   end else if (m_arm != 0 && !(m_why == 2 && fifo_full)) begin
                       t_drop = 1; t_st = 2; t_why = 0;
                   end
            endcase
            t_arm = (t_drop != 0) ? 0 : ((m_arm != 0 || t_acc != 0) ? 1 : 0);
            m_st = t_st; m_why = t_why; m_arm = t_arm; m_bytes = t_bytes;
            m_blocks = t_blocks; m_done = t_done;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R2 xfer_en vs model", 32'(xfer_en), 32'(m_st == 2));
            chk("R11 halted vs model", 32'(halted), 32'(m_st == 3));
            chk("R11 halt_why vs model", 32'(halt_why), 32'(m_why));
            chk("R9 done vs model", 32'(done), 32'(m_done));
            chk("R3 arm_flag vs model", 32'(arm_flag), 32'(m_arm));
            chk("R6 bytes_left vs model", 32'(bytes_left), 32'(m_bytes));
            chk("R6 blocks_left vs model", 32'(blocks_left), 32'(m_blocks));
        end
    end

    task automatic pulse_den();    @(negedge clk) den_wr = 1;    @(negedge clk) den_wr = 0;    endtask
    task automatic pulse_rcont();  @(negedge clk) rcont_wr = 1;  @(negedge clk) rcont_wr = 0;  endtask
    task automatic pulse_off();    @(negedge clk) cmd_off = 1;   @(negedge clk) cmd_off = 0;   endtask
    task automatic pulse_resp();   @(negedge clk) resp_done = 1; @(negedge clk) resp_done = 0; endtask
    task automatic stream(input int n);
        for (int i = 0; i < n; i++) @(negedge clk) byte_stb = 1;
        @(negedge clk) byte_stb = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 xfer_en after reset", 32'(xfer_en), 0);
        chk("R1 halted after reset", 32'(halted), 0);
        chk("R1 blocks_left after reset", 32'(blocks_left), 0);

        // stray controls while idle
        pulse_den();
        chk("R2 den in idle ignored", 32'(arm_flag), 0);
        pulse_off();
        chk("R7 cmd_off in idle ignored", 32'(done), 0);

        // write: 2 blocks of 4, no auto
        blk_len = 4; blk_cnt = 2; dir_rd = 0; auto_mode = 0;
        pulse_resp();
        repeat (3) @(negedge clk);
        chk("R2 write waits for den", 32'(xfer_en), 0);
        chk("R6 bytes loaded", 32'(bytes_left), 4);
        pulse_den();
        chk("R3 arm set after den", 32'(arm_flag), 1);
        @(negedge clk);
        chk("R3 arm self-cleared", 32'(arm_flag), 0);
        chk("R2 write started", 32'(xfer_en), 1);
        byte_stb = 1; repeat (3) @(negedge clk);
        stream(0);
        chk("R6 halt at block end", 32'(halt_why), 3);
        chk("R6 bytes reloaded", 32'(bytes_left), 4);
        chk("R6 blocks decremented", 32'(blocks_left), 1);
        byte_stb = 1; repeat (2) @(negedge clk); byte_stb = 0;
        chk("R10 strobe while halted ignored", 32'(bytes_left), 4);
        pulse_den();
        @(negedge clk);
        chk("R11 why cleared on resume", 32'(halt_why), 0);
        stream(1);
        chk("R10 strobe counted when enabled", 32'(bytes_left), 3);
        pulse_den();
        chk("R2 den while running ignored", 32'(arm_flag), 0);
        fifo_empty = 1;
        @(negedge clk);
        chk("R4 halt on fifo empty", 32'(halt_why), 1);
        chk("R4 transfer stopped", 32'(xfer_en), 0);
        fifo_empty = 0;
        pulse_den();
        @(negedge clk);
        chk("R4 resumed by den", 32'(xfer_en), 1);
        byte_stb = 1; repeat (2) @(negedge clk);
        stream(0);
        chk("R9 done pulse", 32'(done), 1);
        chk("R9 blocks zero", 32'(blocks_left), 0);
        @(negedge clk);
        chk("R9 done one cycle", 32'(done), 0);

        // read: 2 blocks of 3, stall on full, then abort at boundary
        blk_len = 3; blk_cnt = 2; dir_rd = 1;
        pulse_resp();
        chk("R2 read starts at once", 32'(xfer_en), 1);
        pulse_off();
        chk("R7 cmd_off while running ignored", 32'(xfer_en), 1);
        fifo_full = 1;
        @(negedge clk);
        chk("R5 halt on fifo full", 32'(halt_why), 2);
        pulse_rcont();
        @(negedge clk);
        chk("R5 held while still full", 32'(halted), 1);
        chk("R5 arm pending", 32'(arm_flag), 1);
        fifo_full = 0;
        @(negedge clk);
        chk("R5 resume when space", 32'(xfer_en), 1);
        byte_stb = 1; repeat (2) @(negedge clk);
        stream(0);
        chk("R6 read block halt", 32'(halt_why), 3);
        pulse_off();
        chk("R7 abort done", 32'(done), 1);
        chk("R7 abort to idle", 32'(halted), 0);
        chk("R7 abort clears counters", 32'(bytes_left), 0);

        // auto write: 3 blocks of 2
        blk_len = 2; blk_cnt = 3; dir_rd = 0; auto_mode = 1;
        pulse_resp();
        pulse_den();
        @(negedge clk);
        stream(2);
        chk("R8 no halt at boundary", 32'(halted), 0);
        chk("R8 still enabled", 32'(xfer_en), 1);
        chk("R8 blocks counted", 32'(blocks_left), 2);
        byte_stb = 1; repeat (3) @(negedge clk);
        stream(0);
        chk("R8 auto completes", 32'(done), 1);

        // reset mid-transfer
        auto_mode = 0; blk_len = 4; blk_cnt = 2;
        pulse_resp();
        pulse_den();
        @(negedge clk);
        stream(1);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R1 reset stops transfer", 32'(xfer_en), 0);
        chk("R1 reset clears bytes", 32'(bytes_left), 0);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule